// File: doc/BRIEF.md
# DMA Test Control Register

This block is a byte-wide read/write control register that sits beside a DMA engine and gives test software direct control over it. Writing it can request a single advance of the engine's next-address pointer or a single decrement of its 24-bit byte counter. These requests are one-shot strobes that clear themselves. The register also selects the FIFO depth that the engine reports, and it sets or clears the engine's internal write-direction signal. It stores two upper byte-offset bits and one spare bit.

The two strobe bits are run by a four-state machine. The states are `ST_IDLE`, with no strobe; `ST_ADDR`, for an address advance; `ST_CNT`, for a count decrement; and `ST_BOTH`, for both strobes together. On every write the next state comes from write bits 7 and 6: `00` goes to `ST_IDLE`, `10` to `ST_ADDR`, `01` to `ST_CNT` and `11` to `ST_BOTH`. With no write, every state goes to `ST_IDLE`. So a strobe state lasts one clock unless another write takes its place.

The step applied by either strobe is computed from the current address and count. It is the distance from the address to the next 4-byte boundary (1 to 4 bytes), reduced to the byte count when the count is smaller. A count of 0 gives a step of 0.

The direction bit is not stored directly. Writing 1 to bit 3 copies the master bit that was already stored into the direction signal. The master bit is bit 4, and a new master value in the same write has no effect on that write.

Top module: `dma_test_ctl`

## Requirements
- R1: After reset, `rd_data` is 0x00, `dma_wr_dir` is 0, both strobe outputs and both step amounts are 0, `fifo_big` is 0 and `fifo_depth` is 112.
- R2: A write with bit 7 = 1 raises `adr_step_pulse` for exactly the one clock after the write. During that clock `rd_data[7]` reads 1, and afterwards it reads 0.
- R3: A write with bit 6 = 1 raises `cnt_step_pulse` for exactly the one clock after the write. During that clock `rd_data[6]` reads 1, and afterwards it reads 0.
- R4: While a strobe is high, its amount output equals min(4 − `cur_addr[1:0]`, `cur_count`), and it is 0 when `cur_count` is 0. While the strobe is low, its amount is 0.
- R5: Bit 5 is stored and read back. When it is 1, `fifo_big` is 1 and `fifo_depth` is 944. When it is 0, `fifo_big` is 0 and `fifo_depth` is 112.
- R6: A write with bit 3 = 1 sets `dma_wr_dir` to the value bit 4 held before that write. A write with bit 3 = 0 leaves `dma_wr_dir` unchanged. `rd_data[3]` returns `dma_wr_dir` and `rd_data[4]` returns the stored master bit.
- R7: Bit 2 and bits 1:0 are plain stored bits and read back as written. Bits 1:0 also drive `offset_hi`.
- R8: A write with bits 7 and 6 both set raises both strobes in the same clock, and both carry the same amount.
- R9: A write that arrives while a strobe is high replaces the strobe state with the one selected by its own bits 7:6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| cur_addr | input | ADDR_W (32) | Current next-address pointer value |
| cur_count | input | CNT_W (24) | Current byte counter value |
| rd_data | output | 8 | Register read value |
| adr_step_pulse | output | 1 | One-clock address advance strobe |
| adr_step_amt | output | 3 | Address advance amount in bytes |
| cnt_step_pulse | output | 1 | One-clock count decrement strobe |
| cnt_step_amt | output | 3 | Count decrement amount in bytes |
| fifo_big | output | 1 | Large FIFO depth selected |
| fifo_depth | output | 10 | Reported FIFO depth in bytes |
| dma_wr_dir | output | 1 | Internal DMA write-direction signal |
| offset_hi | output | 2 | Upper byte-offset bits |

## Verification
The address advance and the count decrement can fall in the same cycle. The bench provokes this with a single write that sets bits 7 and 6, made at an address near a word boundary and with a small count. It then checks that both strobes rise together and carry the same clipped amount. A second case writes the two strobes back to back, so that the count write lands during the address pulse, and checks that the new write takes over the pulse cleanly. The direction path is also tested against a write that changes the master bit and sets bit 3 together, and that write must follow the old master value.

// File: rtl/dmatc_pkg.sv
package dmatc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_CNT  = 2'd2,
        ST_BOTH = 2'd3
    } strobe_st_e;

    localparam int BIT_ADV   = 7;
    localparam int BIT_DEC   = 6;
    localparam int BIT_FIFO  = 5;
    localparam int BIT_MST   = 4;
    localparam int BIT_DIR   = 3;
    localparam int BIT_SPARE = 2;
    localparam int OFF_W     = 2;
endpackage

// File: rtl/dmatc_step_calc.sv
module dmatc_step_calc #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24,
    parameter int STEP_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  count,
    output logic [STEP_W-1:0] step
);
    localparam int WORD_B = 4;

    logic [STEP_W-1:0] room;

    always_comb begin
        room = STEP_W'(WORD_B) - {{(STEP_W-2){1'b0}}, addr[1:0]};
        if (count == '0) begin
            step = '0;
        end else if (count < CNT_W'(room)) begin
            step = count[STEP_W-1:0];
        end else begin
            step = room;
        end
    end
endmodule

// File: rtl/dmatc_strobe_fsm.sv
module dmatc_strobe_fsm
    import dmatc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic req_adv,
    input  logic req_dec,
    output logic adv_pulse,
    output logic dec_pulse
);
    strobe_st_e state_q, state_n;

    always_comb begin
        state_n = ST_IDLE;
        if (wr_en) begin
            unique case ({req_adv, req_dec})
                2'b10:   state_n = ST_ADDR;
                2'b01:   state_n = ST_CNT;
                2'b11:   state_n = ST_BOTH;
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: begin adv_pulse = 1'b0; dec_pulse = 1'b0; end
            ST_ADDR: begin adv_pulse = 1'b1; dec_pulse = 1'b0; end
            ST_CNT:  begin adv_pulse = 1'b0; dec_pulse = 1'b1; end
            ST_BOTH: begin adv_pulse = 1'b1; dec_pulse = 1'b1; end
            default: begin adv_pulse = 1'b0; dec_pulse = 1'b0; end
        endcase
    end

    // R2
    adv_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_pulse && !wr_en) |=> !adv_pulse);

    // R3
    dec_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_pulse && !wr_en) |=> !dec_pulse);

    // R8
    both_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && req_adv && req_dec) |=> (adv_pulse && dec_pulse));
endmodule

// File: rtl/dmatc_dir_ctl.sv
module dmatc_dir_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_dir,
    input  logic wr_master,
    output logic master_q,
    output logic dir_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            master_q <= 1'b0;
            dir_q    <= 1'b0;
        end else if (wr_en) begin
            master_q <= wr_master;
            if (wr_dir) dir_q <= master_q;
        end
    end

    // R6
    dir_follows_old_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_dir) |=> (dir_q == $past(master_q)));

    // R6
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_dir) |=> $stable(dir_q));
endmodule

// File: rtl/dma_test_ctl.sv
module dma_test_ctl
    import dmatc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 24,
    parameter int STEP_W      = 3,
    parameter int DEPTH_W     = 10,
    parameter int SMALL_DEPTH = 112,
    parameter int LARGE_DEPTH = 944
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    input  logic [ADDR_W-1:0]  cur_addr,
    input  logic [CNT_W-1:0]   cur_count,
    output logic [7:0]         rd_data,
    output logic               adr_step_pulse,
    output logic [STEP_W-1:0]  adr_step_amt,
    output logic               cnt_step_pulse,
    output logic [STEP_W-1:0]  cnt_step_amt,
    output logic               fifo_big,
    output logic [DEPTH_W-1:0] fifo_depth,
    output logic               dma_wr_dir,
    output logic [OFF_W-1:0]   offset_hi
);
    logic              fifo_q;
    logic              spare_q;
    logic [OFF_W-1:0]  off_q;
    logic              master_q;
    logic [STEP_W-1:0] step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_q  <= 1'b0;
            spare_q <= 1'b0;
            off_q   <= '0;
        end else if (wr_en) begin
            fifo_q  <= wr_data[BIT_FIFO];
            spare_q <= wr_data[BIT_SPARE];
            off_q   <= wr_data[OFF_W-1:0];
        end
    end

    dmatc_strobe_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .req_adv   (wr_data[BIT_ADV]),
        .req_dec   (wr_data[BIT_DEC]),
        .adv_pulse (adr_step_pulse),
        .dec_pulse (cnt_step_pulse)
    );

    dmatc_dir_ctl u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_dir    (wr_data[BIT_DIR]),
        .wr_master (wr_data[BIT_MST]),
        .master_q  (master_q),
        .dir_q     (dma_wr_dir)
    );

    dmatc_step_calc #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .STEP_W (STEP_W)
    ) u_step (
        .addr  (cur_addr),
        .count (cur_count),
        .step  (step)
    );

    always_comb begin
        adr_step_amt = adr_step_pulse ? step : '0;
        cnt_step_amt = cnt_step_pulse ? step : '0;
        fifo_big     = fifo_q;
        fifo_depth   = fifo_q ? DEPTH_W'(LARGE_DEPTH) : DEPTH_W'(SMALL_DEPTH);
        offset_hi    = off_q;
        rd_data      = {adr_step_pulse, cnt_step_pulse, fifo_q, master_q,
                        dma_wr_dir, spare_q, off_q};
    end

    // R4
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adr_step_pulse |-> (adr_step_amt <= STEP_W'(4)
                            && CNT_W'(adr_step_amt) <= cur_count));

    // R4
    idle_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_step_pulse |-> (cnt_step_amt == '0));

    // R5
    fifo_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (fifo_big == $past(wr_data[BIT_FIFO])));

    // R8
    same_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adr_step_pulse && cnt_step_pulse) |-> (adr_step_amt == cnt_step_amt));
endmodule

// File: tb/dma_test_ctl_bench.sv
module dma_test_ctl_bench;
    localparam int CLK_P = 10;

    typedef struct {
        logic       ap;
        logic       cp;
        logic [2:0] amt;
        logic       dir;
        logic       big;
        logic [9:0] dep;
        logic [7:0] rd;
        logic [1:0] off;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [31:0] cur_addr = 32'h0;
    logic [23:0] cur_count = 24'h0;
    logic [7:0]  rd_data;
    logic        adr_step_pulse, cnt_step_pulse, fifo_big, dma_wr_dir;
    logic [2:0]  adr_step_amt, cnt_step_amt;
    logic [9:0]  fifo_depth;
    logic [1:0]  offset_hi;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    exp_t q[$];

    // model state
    logic m_mst = 1'b0, m_dir = 1'b0, m_big = 1'b0, m_sp = 1'b0;
    logic [1:0] m_off = 2'b00;

    always #(CLK_P/2) clk = ~clk;

    dma_test_ctl u_dma_test_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cur_addr(cur_addr), .cur_count(cur_count), .rd_data(rd_data),
        .adr_step_pulse(adr_step_pulse), .adr_step_amt(adr_step_amt),
        .cnt_step_pulse(cnt_step_pulse), .cnt_step_amt(cnt_step_amt),
        .fifo_big(fifo_big), .fifo_depth(fifo_depth), .dma_wr_dir(dma_wr_dir),
        .offset_hi(offset_hi)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_step(logic [31:0] a, logic [23:0] c);
        int room = 4 - int'(a[1:0]);
        if (c == 0) return 3'd0;
        if (int'(c) < room) return c[2:0];
        return 3'(room);
    endfunction

    function automatic exp_t build(logic ap, logic cp, string tag);
        exp_t e;
        e.ap  = ap;
        e.cp  = cp;
        e.amt = exp_step(cur_addr, cur_count);
        e.dir = m_dir;
        e.big = m_big;
        e.dep = m_big ? 10'd944 : 10'd112;
        e.rd  = {ap, cp, m_big, m_mst, m_dir, m_sp, m_off};
        e.off = m_off;
        e.tag = tag;
        return e;
    endfunction

    task automatic do_write(logic [7:0] d, logic [31:0] a, logic [23:0] c, string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; cur_addr = a; cur_count = c;
        if (d[3]) m_dir = m_mst;
        m_mst = d[4]; m_big = d[5]; m_sp = d[2]; m_off = d[1:0];
        q.push_back(build(d[7], d[6], tag));
    endtask

    task automatic do_idle(string tag);
        @(negedge clk);
        wr_en = 1'b0;
        q.push_back(build(1'b0, 1'b0, tag));
    endtask

    // monitor: compare one expected item per clock after the capturing edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                check({"R2 adr pulse ", e.tag}, 32'(adr_step_pulse), 32'(e.ap));
                check({"R3 cnt pulse ", e.tag}, 32'(cnt_step_pulse), 32'(e.cp));
                check({"R4 adr amt ", e.tag}, 32'(adr_step_amt), e.ap ? 32'(e.amt) : 32'd0);
                check({"R4 cnt amt ", e.tag}, 32'(cnt_step_amt), e.cp ? 32'(e.amt) : 32'd0);
                check({"R6 dir ", e.tag}, 32'(dma_wr_dir), 32'(e.dir));
                check({"R5 fifo ", e.tag}, {21'd0, fifo_big, fifo_depth}, {21'd0, e.big, e.dep});
                check({"R7 rd ", e.tag}, 32'(rd_data), 32'(e.rd));
                check({"R7 off ", e.tag}, 32'(offset_hi), 32'(e.off));
            end
        end
    end

    initial begin
        #(CLK_P * 5000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 2 + 1);
        // R1 reset state
        check("R1 rd", 32'(rd_data), 32'h0);
        check("R1 dir", 32'(dma_wr_dir), 32'h0);
        check("R1 pulses", {adr_step_pulse, cnt_step_pulse, adr_step_amt, cnt_step_amt}, 32'h0);
        check("R1 fifo", {fifo_big, fifo_depth}, 32'd112);
        @(negedge clk);
        rst_n = 1'b1;
        // R2 address strobe, unaligned address, step 3
        do_write(8'h80, 32'h1001, 24'd100, "R2 adv");
        do_idle("R2 after");
        do_idle("R2 after2");
        // R3 / R4 count strobe clipped by count
        do_write(8'h40, 32'h2000, 24'd2, "R3 dec clip");
        do_idle("R3 after");
        // R4 zero count
        do_write(8'h40, 32'h2002, 24'd0, "R4 zero count");
        do_idle("R4 after");
        // R8 both strobes at once
        do_write(8'hC0, 32'h0003, 24'd50, "R8 both");
        do_idle("R8 after");
        // R9 back-to-back replacement
        do_write(8'h80, 32'h0004, 24'd9, "R9 first");
        do_write(8'h40, 32'h0006, 24'd9, "R9 second");
        do_idle("R9 after");
        // R6 master/direction
        do_write(8'h10, 32'h0, 24'd0, "R6 set master");
        do_write(8'h18, 32'h0, 24'd0, "R6 assert dir");
        do_write(8'h00, 32'h0, 24'd0, "R6 hold dir");
        do_write(8'h18, 32'h0, 24'd0, "R6 same-write master");
        do_write(8'h18, 32'h0, 24'd0, "R6 reassert");
        do_write(8'h08, 32'h0, 24'd0, "R6 deassert");
        // R5 FIFO depth and R7 plain bits
        do_write(8'h27, 32'h0, 24'd0, "R5 big R7 bits");
        do_idle("R5 hold");
        do_write(8'h02, 32'h0, 24'd0, "R5 small R7 off");
        do_idle("end");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule